// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a processor's register bus and a four-input, 12-bit analog-to-digital converter. Software programs one 16-bit control word. That word enables the unit, picks the input to convert, chooses the conversion length, and gates the interrupt request. Software then starts either one conversion or a stream of conversions at a fixed 8 kHz rate. The converter itself is outside this block: each input appears as a 12-bit bus that the block samples at the end of a conversion.

Conversion timing is counted in cycles of the 27 MHz clock the block runs on. A single conversion lasts a power-of-two number of cycles. The repeat period is the clock rate divided by the repeat rate. When a conversion completes, the block loads a data word that carries a valid flag and sets a ready flag. If interrupts are enabled, it also raises an interrupt request, which stays high until software acknowledges it by writing the ready flag back as 1.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset the control word, the data word and the interrupt request all read 0.
- R2: A control write with bit 0 set starts a single conversion only when it writes bit 12 as 1 and the stored bit 12 is 0. The start clears stored bit 12, ready (bit 13) and data-valid (data bit 15) in the next cycle.
- R3: A single conversion completes exactly 16 << (control bits 3:2) clock edges after the edge that accepted the start write, giving 16, 32, 64 or 128 cycles.
- R4: On completion the data word reads bit 15 = 1, bits 14:12 = 0, and bits 11:0 = the input bus picked by control bits 5:4 (0 to 3).
- R5: Ready (control bit 13) goes to 1 on completion. Any write with bit 0 set also leaves ready at 1 when no single conversion is in flight, unless that write starts one or acknowledges.
- R6: A completion raises the interrupt request only when control bit 9 is 1.
- R7: A write with bit 13 = 1 while ready reads 1 clears ready and drops the interrupt request.
- R8: A write with bits 0 and 10 set clears data-valid and starts conversions that repeat every CLK_HZ/REPEAT_HZ cycles (3375 by default). Bit 10 reads back as 1 while repeating. A later write with bit 10 = 0 stops the repetition.
- R9: A write with bit 0 = 0 stops any pending conversion of either kind and forces ready to read 0.
- R10: Writing bit 12 as 1 while it already reads 1 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control-word write strobe, one cycle per write |
| ctrl_wdata | input | 16 | Control word being written |
| ctrl_rdata | output | 16 | Control word readback |
| data_rdata | output | 16 | Conversion result with valid flag |
| analog_in | input | NUM_CH*SAMPLE_W | Converter inputs, channel 0 in the low bits |
| adc_irq | output | 1 | Interrupt request, level |

## Verification
A countdown left one cycle off would move the ready flag and the data-valid flag by that cycle. The bench checks the cycle just before the expected completion as well as the completion cycle itself, so such a slip shows up at once. A channel-select or packing error puts a wrong sample into the data word, and that word is compared in full at every completion. A stale start bit or a stale repeat timer shows only later. It appears as a conversion that should not happen, or one that is missing, hundreds or thousands of cycles after the write that should have settled it. The bench therefore waits past the longest window before it reads the data word again.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int CTL_W = 16;

   typedef struct packed {
      logic       rdy;
      logic       start;
      logic       rep;
      logic       ie;
      logic [1:0] ch;
      logic [1:0] tsel;
      logic       en;
   } ctl_t;

   function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
      logic [CTL_W-1:0] w;
      w       = '0;
      w[0]    = c.en;
      w[3:2]  = c.tsel;
      w[5:4]  = c.ch;
      w[9]    = c.ie;
      w[10]   = c.rep;
      w[12]   = c.start;
      w[13]   = c.rdy;
      return w;
   endfunction
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int CNT_W    = 8,
   parameter bit PERIODIC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             kill,
   input  logic             hold,
   input  logic [CNT_W-1:0] load_val,
   output logic             active,
   output logic             fire
);
   initial assert (CNT_W >= 2) else $error("adc_seq_timer: CNT_W too small");

   logic [CNT_W-1:0] cnt_q;
   logic             act_q;
   logic             rearm;

   generate
      if (PERIODIC) begin : g_periodic
         assign rearm = 1'b1;
      end else begin : g_oneshot
         assign rearm = 1'b0;
      end
   endgenerate

   assign fire   = act_q && (cnt_q == CNT_W'(1)) && !hold;
   assign active = act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (kill) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (load) begin
         act_q <= 1'b1;
         cnt_q <= load_val;
      end else if (act_q && cnt_q > CNT_W'(1)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end else if (fire) begin
         act_q <= rearm;
         cnt_q <= rearm ? load_val : '0;
      end
   end

   AST_LOAD_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      load && !kill |=> active && !fire) else $error("fire right after load"); // R3
   AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !active) else $error("timer alive after kill"); // R9
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
   parameter int NUM_CH   = 4,
   parameter int SAMPLE_W = 12,
   parameter int CH_W     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH*SAMPLE_W-1:0] samples,
   input  logic [CH_W-1:0]            ch_sel,
   input  logic                       capture,
   input  logic                       invalidate,
   output logic [15:0]                data
);
   initial assert (SAMPLE_W >= 1 && SAMPLE_W <= 12) else $error("adc_seq_capture: SAMPLE_W out of range");

   localparam int PAD_W = 15 - SAMPLE_W;

   logic [SAMPLE_W-1:0] smp;
   logic [15:0]         data_q;

   always_comb begin
      smp = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (ch_sel == CH_W'(i)) smp = samples[i*SAMPLE_W +: SAMPLE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          data_q <= '0;
      else if (capture)    data_q <= {1'b1, {PAD_W{1'b0}}, smp};
      else if (invalidate) data_q[15] <= 1'b0;
   end

   assign data = data_q;

   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      data[14:SAMPLE_W] == '0) else $error("reserved data bits set"); // R4
   AST_CAPTURE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> data[15]) else $error("capture without valid"); // R4
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_seq_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter int NUM_CH    = 4,
   parameter int CLK_HZ    = 27_000_000,
   parameter int REPEAT_HZ = 8000,
   parameter int BASE_CLKS = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ctrl_wr,
   input  logic [15:0]                ctrl_wdata,
   output logic [15:0]                ctrl_rdata,
   output logic [15:0]                data_rdata,
   input  logic [NUM_CH*SAMPLE_W-1:0] analog_in,
   output logic                       adc_irq
);
   localparam int CH_W       = 2;
   localparam int REP_PERIOD = CLK_HZ / REPEAT_HZ;
   localparam int MAX_CONV   = BASE_CLKS << 3;
   localparam int ONE_W      = $clog2(MAX_CONV + 1);
   localparam int REP_W      = $clog2(REP_PERIOD + 1);

   initial assert (NUM_CH >= 1 && NUM_CH <= 4) else $error("adc_conv_seq: NUM_CH must be 1..4");
   initial assert (REP_PERIOD > MAX_CONV) else $error("adc_conv_seq: repeat period too short");
   initial assert (BASE_CLKS >= 2) else $error("adc_conv_seq: BASE_CLKS too small");

   ctl_t ctl_q;
   logic pend_q;

   // write decode
   logic w_en, w_start, w_rep, w_stop_rep, w_kill, w_ack;
   assign w_en       = ctrl_wdata[0];
   assign w_start    = ctrl_wr && w_en && ctrl_wdata[12] && !ctl_q.start;
   assign w_rep      = ctrl_wr && w_en && ctrl_wdata[10];
   assign w_stop_rep = ctrl_wr && !(w_en && ctrl_wdata[10]);
   assign w_kill     = ctrl_wr && !w_en;
   assign w_ack      = ctrl_wr && ctrl_wdata[13] && ctl_q.rdy;

   logic unused_wbits;
   assign unused_wbits = ^{ctrl_wdata[15:14], ctrl_wdata[11], ctrl_wdata[8:6], ctrl_wdata[1]};

   logic [ONE_W-1:0] conv_len;
   assign conv_len = ONE_W'(BASE_CLKS) << ctrl_wdata[3:2];

   logic one_busy, one_fire, rep_busy, rep_fire, done;

   adc_seq_timer #(.CNT_W(ONE_W), .PERIODIC(1'b0)) u_single (
      .clk(clk), .rst_n(rst_n), .load(w_start), .kill(w_kill), .hold(ctrl_wr),
      .load_val(conv_len), .active(one_busy), .fire(one_fire));

   adc_seq_timer #(.CNT_W(REP_W), .PERIODIC(1'b1)) u_repeat (
      .clk(clk), .rst_n(rst_n), .load(w_rep), .kill(w_stop_rep), .hold(ctrl_wr),
      .load_val(REP_W'(REP_PERIOD)), .active(rep_busy), .fire(rep_fire));

   assign done = one_fire || rep_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         pend_q <= 1'b0;
      end else if (ctrl_wr) begin
         ctl_q.en    <= w_en;
         ctl_q.tsel  <= ctrl_wdata[3:2];
         ctl_q.ch    <= ctrl_wdata[5:4];
         ctl_q.ie    <= ctrl_wdata[9];
         ctl_q.rep   <= w_en && ctrl_wdata[10];
         ctl_q.start <= w_start ? 1'b0 : ctrl_wdata[12];
         ctl_q.rdy   <= (!w_en || w_ack || w_start) ? 1'b0 : !one_busy;
         if (w_ack) pend_q <= 1'b0;
      end else if (done) begin
         ctl_q.rdy <= 1'b1;
         if (ctl_q.ie) pend_q <= 1'b1;
      end
   end

   adc_seq_capture #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .samples(analog_in), .ch_sel(ctl_q.ch),
      .capture(done), .invalidate(w_start || w_rep), .data(data_rdata));

   assign ctrl_rdata = ctl_pack(ctl_q);
   assign adc_irq    = pend_q;

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      w_start |=> !ctrl_rdata[13] && !ctrl_rdata[12] && !data_rdata[15]) else $error("start flags"); // R2
   AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_irq) |-> ctrl_rdata[9]) else $error("irq without enable"); // R6
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      w_ack |=> !adc_irq && !ctrl_rdata[13]) else $error("ack ignored"); // R7
   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_rdata[0] |-> !ctrl_rdata[13] && !one_busy && !rep_busy) else $error("busy while off"); // R9
   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ctrl_rdata[13] && data_rdata[15]) else $error("done without ready"); // R5
   AST_REP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rep_busy |-> ctrl_rdata[10]) else $error("repeat without flag"); // R8
endmodule

// File: tb/adc_conv_seq_test.sv
`timescale 1ns/1ps
module adc_conv_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [15:0] ctrl_wdata = '0;
   logic [15:0] ctrl_rdata, data_rdata;
   logic        adc_irq;
   logic [11:0] smp [4];
   logic [47:0] analog_in;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   localparam int PERIOD = 27_000_000 / 8000;
   // {tsel, ch, ie}
   localparam logic [4:0] VEC [4] = '{5'b00_00_1, 5'b01_01_0, 5'b10_10_1, 5'b11_11_1};

   always #4 clk = ~clk;

   assign analog_in = {smp[3], smp[2], smp[1], smp[0]};

   adc_conv_seq uut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata), .analog_in(analog_in),
      .adc_irq(adc_irq));

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] v);
      @(negedge clk);
      ctrl_wr    = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr    = 1'b0;
      ctrl_wdata = '0;
   endtask

   task automatic wait_cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      smp[0] = 12'h123; smp[1] = 12'hABC; smp[2] = 12'hFFF; smp[3] = 12'h800;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(1);
      check(ctrl_rdata == 16'h0, "R1 ctrl", ctrl_rdata, 0);
      check(data_rdata == 16'h0, "R1 data", data_rdata, 0);
      check(adc_irq == 1'b0, "R1 irq", adc_irq, 0);

      for (int v = 0; v < 4; v++) begin
         logic [1:0] ts, ch;
         logic ie;
         int n;
         logic [15:0] exp_d;
         {ts, ch, ie} = VEC[v];
         n = 16 << ts;
         exp_d = 16'h8000 | {4'h0, smp[ch]};
         wr(16'h1000 | 16'h0001 | {14'h0, ts} << 2 | {14'h0, ch} << 4 | {15'h0, ie} << 9);
         check(ctrl_rdata[13:12] == 2'b00 && !data_rdata[15], "R2 start clears", {ctrl_rdata[13:12], data_rdata[15]}, 0);
         wait_cyc(n - 1);
         check(!ctrl_rdata[13] && !data_rdata[15], "R3 not yet done", {ctrl_rdata[13], data_rdata[15]}, 0);
         wait_cyc(1);
         check(ctrl_rdata[13], "R5 ready on done", ctrl_rdata[13], 1);
         check(data_rdata == exp_d, "R4 data word", data_rdata, exp_d);
         check(adc_irq == ie, "R6 irq gate", adc_irq, ie);
         wr(16'h2001 | {15'h0, ie} << 9);
         check(!ctrl_rdata[13] && !adc_irq, "R7 ack", {ctrl_rdata[13], adc_irq}, 0);
      end

      // R5: enabled write with nothing in flight presumes ready
      wr(16'h0001);
      check(ctrl_rdata[13], "R5 presumed ready", ctrl_rdata[13], 1);

      // R8 repeating conversions
      wr(16'h0401);
      check(ctrl_rdata[10] && !data_rdata[15], "R8 repeat armed", {ctrl_rdata[10], data_rdata[15]}, 2'b10);
      wait_cyc(PERIOD - 1);
      check(!data_rdata[15], "R8 before first", data_rdata, 0);
      wait_cyc(1);
      check(data_rdata == 16'h8123, "R8 first sample", data_rdata, 16'h8123);
      smp[0] = 12'h456;
      wait_cyc(PERIOD);
      check(data_rdata == 16'h8456, "R8 second sample", data_rdata, 16'h8456);
      wr(16'h0001);
      check(!ctrl_rdata[10], "R8 repeat stopped", ctrl_rdata[10], 0);
      smp[0] = 12'h777;
      wait_cyc(PERIOD + 10);
      check(data_rdata == 16'h8456, "R8 no more samples", data_rdata, 16'h8456);

      // R9 disable stops in-flight conversion
      wr(16'h100D);
      wait_cyc(10);
      wr(16'h0000);
      check(ctrl_rdata == 16'h0, "R9 ctrl off", ctrl_rdata, 0);
      wait_cyc(200);
      check(!data_rdata[15] && !ctrl_rdata[13], "R9 no completion", {data_rdata[15], ctrl_rdata[13]}, 0);

      // R10 held start bit
      wr(16'h1000);
      check(ctrl_rdata[12], "R10 start stored", ctrl_rdata[12], 1);
      wr(16'h1001);
      check(ctrl_rdata[13] && ctrl_rdata[12], "R10 no start", ctrl_rdata[13:12], 2'b11);
      wait_cyc(40);
      check(!data_rdata[15], "R10 no conversion", data_rdata[15], 0);

      finish_run();
   end

   initial begin
      for (int k = 0; k < 150000; k++) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule